// File: doc/BRIEF.md
# I2C Indexed Block Register Slave

This block is an I2C target that serves a small map of eight byte-wide registers. It watches oversampled SCL and SDA lines, answers one fixed 7-bit address, and pulls SDA low through an open-drain enable to acknowledge a byte or to send a 0 bit. The registers drive two output-enable flags and two 8-bit divider settings. Their values appear directly on output ports.

A write names a starting offset and a byte count, then sends that many data bytes. Each data byte lands at the next offset. A read first sets the offset with a short write, then issues a repeated START with the read address. The target returns a count byte and then register contents, and stops when the host answers a byte with NACK. A START or STOP on the bus always takes back control of the sequence.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, both output enables read 1 (enabled), divider 1 is 0x0F, divider 2 is 0x2E, and SDA is released.
- R2: Only the 7-bit address 1101010 is acknowledged, as address byte 0xD4 (write) or 0xD5 (read). Any other address byte gets no ACK, and every byte up to the next START or STOP is ignored.
- R3: A write is the address, an offset byte, a count byte X and then X data bytes. The target acknowledges each of them and stores the data at consecutive offsets, starting at the offset given.
- R4: Data bytes beyond the count X are not acknowledged and not stored. With X = 0, no data byte is accepted.
- R5: After an offset write and a repeated START with 0xD5, the target first sends a count byte equal to 8 minus the offset, and then the register contents starting at the offset.
- R6: The register pointer advances by one for each data byte, read or written, and wraps from 7 to 0. An offset byte is taken modulo 8.
- R7: Register map:
  - Offset 0: bit 5 is the enable for output 3 and bit 4 is the enable for output 4. All other bits of offset 0 read 0.
  - Offset 1: divider 1. Offset 2: divider 2.
  - Offsets 3, 4, 5 and 7 read 0x00.
  - Offset 6 reads 0x01: revision 0 in the upper nibble, vendor 1 in the lower nibble.
  - Writes to read-only bits and read-only bytes have no effect.
- R8: When the host answers a read byte with NACK, the target releases SDA and stays released until the next START.
- R9: A STOP sends the target to idle and a START sends it to address decode, at any point in a transfer. Bytes already acknowledged stay stored.
- R10: Apart from the cycles right after a START or STOP, the target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| out3_en_o | output | 1 | Enable for output 3, offset 0 bit 5 |
| out4_en_o | output | 1 | Enable for output 4, offset 0 bit 4 |
| div1_o | output | 8 | Divider 1 setting, offset 1 |
| div2_o | output | 8 | Divider 2 setting, offset 2 |

## Verification
A pointer that drifts shows up within one byte. It either writes a divider port at the wrong offset, or changes the count byte or data of the next read. A sequence state that misses a START, STOP or NACK shows up within one bit time. Either an ACK appears where none belongs, or SDA stays pulled when the host expects it released. A stray write to a read-only location is caught by reading that location back, and by checking that the enable and divider ports do not move.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned MAP_DEPTH = 8;
  localparam int unsigned AW        = $clog2(MAP_DEPTH);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_OFFS,
    ST_OACK,
    ST_CNT,
    ST_CACK,
    ST_WDAT,
    ST_WACK,
    ST_TX,
    ST_MACK
  } xfer_state_e;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_hi_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d_q, sda_d_q;
  logic              scl_s, sda_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s;
      sda_d_q <= sda_s;
    end
  end

  assign scl_hi_o   = scl_s;
  assign sda_hi_o   = sda_s;
  assign scl_rise_o = scl_s & ~scl_d_q;
  assign scl_fall_o = ~scl_s & scl_d_q;
  assign start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] DIV1_RST = 8'h0F,
  parameter logic [7:0] DIV2_RST = 8'h2E,
  parameter logic [7:0] ID_VAL   = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          oe3_o,
  output logic          oe4_o,
  output logic [7:0]    div1_o,
  output logic [7:0]    div2_o
);
  localparam int unsigned OE3_BIT  = 5;
  localparam int unsigned OE4_BIT  = 4;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DIV1 = AW'(1);
  localparam logic [AW-1:0] A_DIV2 = AW'(2);
  localparam logic [AW-1:0] A_ID   = AW'(6);

  logic       oe3_q, oe4_q, oe3_d, oe4_d;
  logic [7:0] div1_q, div2_q, div1_d, div2_d;
  logic       ctrl_we, div1_we, div2_we;

  assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);
  assign div1_we = wr_en_i && (wr_addr_i == A_DIV1);
  assign div2_we = wr_en_i && (wr_addr_i == A_DIV2);

  always_comb begin
    oe3_d  = ctrl_we ? wr_data_i[OE3_BIT] : oe3_q;
    oe4_d  = ctrl_we ? wr_data_i[OE4_BIT] : oe4_q;
    div1_d = div1_we ? wr_data_i : div1_q;
    div2_d = div2_we ? wr_data_i : div2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe3_q  <= 1'b1;
      oe4_q  <= 1'b1;
      div1_q <= DIV1_RST;
      div2_q <= DIV2_RST;
    end else begin
      oe3_q  <= oe3_d;
      oe4_q  <= oe4_d;
      div1_q <= div1_d;
      div2_q <= div2_d;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[OE3_BIT] = oe3_q;
        rd_data_o[OE4_BIT] = oe4_q;
      end
      A_DIV1:  rd_data_o = div1_q;
      A_DIV2:  rd_data_o = div2_q;
      A_ID:    rd_data_o = ID_VAL;
      default: rd_data_o = 8'h00;
    endcase
  end

  assign oe3_o  = oe3_q;
  assign oe4_o  = oe4_q;
  assign div1_o = div1_q;
  assign div2_o = div2_q;

  // R7: with no write strobe, every control field holds its value
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(div1_q) && $stable(div2_q) && $stable(oe3_q) && $stable(oe4_q));

  // R7: a write aimed at offsets 3..7 changes no field
  a_r7_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i > A_DIV2) |=>
      $stable(div1_q) && $stable(div2_q) && $stable(oe3_q) && $stable(oe4_q));
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h6A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_hi_i,
  input  logic          sda_hi_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o
);
  localparam logic [7:0]    DEPTH_B = 8'(MAP_DEPTH);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [3:0]    LAST_BIT = 4'd8;

  xfer_state_e   state_q, state_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    left_q, left_d;
  logic [3:0]    bit_q, bit_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rd_q, rd_d;
  logic          nack_q, nack_d;
  logic          wr_en;
  logic          rx_state;
  logic          byte_done;

  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_OFFS) ||
                     (state_q == ST_CNT)  || (state_q == ST_WDAT);
  assign byte_done = scl_fall_i && (bit_q == LAST_BIT);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    left_d  = left_q;
    bit_d   = bit_q;
    ptr_d   = ptr_q;
    rd_d    = rd_q;
    nack_d  = nack_q;
    wr_en   = 1'b0;

    if (stop_i) begin
      state_d = ST_IDLE;
      bit_d   = 4'd0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      bit_d   = 4'd0;
    end else if (rx_state) begin
      if (scl_rise_i) begin
        sh_d  = {sh_q[6:0], sda_hi_i};
        bit_d = bit_q + 4'd1;
      end else if (byte_done) begin
        bit_d = 4'd0;
        unique case (state_q)
          ST_ADDR: begin
            if (sh_q[7:1] == SLAVE_ADDR) begin
              rd_d    = sh_q[0];
              state_d = ST_AACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_OFFS: begin
            ptr_d   = sh_q[AW-1:0];
            state_d = ST_OACK;
          end
          ST_CNT: begin
            left_d  = sh_q;
            state_d = ST_CACK;
          end
          default: begin
            if (left_q != 8'd0) begin
              wr_en   = 1'b1;
              ptr_d   = ptr_q + PTR_ONE;
              left_d  = left_q - 8'd1;
              state_d = ST_WACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_AACK: if (scl_fall_i) begin
          if (rd_q) begin
            tx_d    = DEPTH_B - {{(8-AW){1'b0}}, ptr_q};
            state_d = ST_TX;
          end else begin
            state_d = ST_OFFS;
          end
        end
        ST_OACK: if (scl_fall_i) state_d = ST_CNT;
        ST_CACK: if (scl_fall_i) state_d = ST_WDAT;
        ST_WACK: if (scl_fall_i) state_d = ST_WDAT;
        ST_TX: begin
          if (scl_rise_i) begin
            bit_d = bit_q + 4'd1;
          end else if (byte_done) begin
            bit_d   = 4'd0;
            state_d = ST_MACK;
          end else if (scl_fall_i) begin
            tx_d = {tx_q[6:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            nack_d = sda_hi_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              tx_d    = rd_data_i;
              ptr_d   = ptr_q + PTR_ONE;
              state_d = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= 8'h00;
      tx_q    <= 8'hFF;
      left_q  <= 8'h00;
      bit_q   <= 4'd0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      ptr_q   <= ptr_d;
      rd_q    <= rd_d;
      nack_q  <= nack_d;
    end
  end

  assign rd_addr_o = ptr_q;
  assign wr_en_o   = wr_en;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = sh_q;
  assign sda_oe_o  = (state_q == ST_AACK) || (state_q == ST_OACK) ||
                     (state_q == ST_CACK) || (state_q == ST_WACK) ||
                     ((state_q == ST_TX) && !tx_q[7]);

  // R6: every stored byte moves the pointer on by one, modulo the map depth
  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> ptr_q == $past(ptr_q) + PTR_ONE);

  // R4: every stored byte uses up one unit of the announced count
  a_r4_count_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> left_q == $past(left_q) - 8'd1);

  // R9: a STOP always lands in idle
  a_r9_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == ST_IDLE);

  // R2: the address acknowledge is only reached from address decode
  a_r2_ack_from_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK) && ($past(state_q) != ST_AACK) |-> $past(state_q) == ST_ADDR);

  // R10: SDA drive is steady while SCL stays high, except just after a bus condition
  a_r10_sda_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hi_i && $past(scl_hi_i) && !$past(start_i) && !$past(stop_i) |-> $stable(sda_oe_o));
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h6A,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0] DIV1_RST    = 8'h0F,
  parameter logic [7:0] DIV2_RST    = 8'h2E,
  parameter logic [7:0] ID_VAL      = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       out3_en_o,
  output logic       out4_en_o,
  output logic [7:0] div1_o,
  output logic [7:0] div2_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          scl_hi, sda_hi, scl_rise, scl_fall, start_c, stop_c;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_hi_o   (scl_hi),
    .sda_hi_o   (sda_hi),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  xfer_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_hi_i   (scl_hi),
    .sda_hi_i   (sda_hi),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  reg_bank #(
    .DIV1_RST (DIV1_RST),
    .DIV2_RST (DIV2_RST),
    .ID_VAL   (ID_VAL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .oe3_o     (out3_en_o),
    .oe4_o     (out4_en_o),
    .div1_o    (div1_o),
    .div2_o    (div2_o)
  );
endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, oe3, oe4;
  logic [7:0] div1, div2;
  wire        sda_bus = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int viol = 0;
  logic done = 1'b0;
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  clkcfg_i2c_slave u_clkcfg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .out3_en_o(oe3), .out4_en_o(oe4),
    .div1_o(div1), .div2_o(div2)
  );

  // {offset, written value, expected read-back}
  localparam logic [18:0] VEC [8] = '{
    {3'd1, 8'hA5, 8'hA5},
    {3'd2, 8'h3C, 8'h3C},
    {3'd0, 8'hFF, 8'h30},
    {3'd0, 8'h00, 8'h00},
    {3'd6, 8'hFF, 8'h01},
    {3'd3, 8'hFF, 8'h00},
    {3'd5, 8'h77, 8'h00},
    {3'd0, 8'h10, 8'h10}
  };

  // R10 monitor: SDA drive must not move while SCL is held high
  always @(posedge clk) begin
    if (rst_n && scl && scl_prev && (sda_oe !== oe_prev)) viol++;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; hold(Q); scl = 1'b1; hold(Q); r = sda_bus; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(nack, r);
  endtask

  task automatic wr_seq(input logic [7:0] adr, input logic [7:0] off, input logic [7:0] cnt,
                        input logic [31:0] dv, input int n, input logic stop,
                        output logic [6:0] acks);
    logic a;
    acks = '0;
    bus_start();
    send_byte(adr, a); acks[0] = a;
    send_byte(off, a); acks[1] = a;
    send_byte(cnt, a); acks[2] = a;
    for (int i = 0; i < n; i++) begin
      send_byte(dv[8*i +: 8], a);
      acks[3+i] = a;
    end
    if (stop) bus_stop();
  endtask

  task automatic rd_seq(input logic [7:0] off, input int n, output logic [2:0] acks);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD4, a); acks[0] = a;
    send_byte(off, a);   acks[1] = a;
    bus_start();
    send_byte(8'hD5, a); acks[2] = a;
    for (int i = 0; i <= n; i++) begin
      recv_byte(i == n, d);
      rbuf[i] = d;
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [6:0] wa;
    logic [2:0] ra;
    logic       r;
    logic [7:0] exp_map [9];
    exp_map = '{8'h30, 8'h0F, 8'h2E, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h30};

    hold(5);
    rst_n = 1'b1;
    hold(10);

    // R1 reset state at the ports
    chk("R1 out3 enable", oe3, 1);
    chk("R1 out4 enable", oe4, 1);
    chk("R1 divider 1", div1, 8'h0F);
    chk("R1 divider 2", div2, 8'h2E);
    chk("R1 sda released", sda_oe, 0);

    // R5 R6 R7 R8: whole map from offset 0, nine bytes to see the wrap
    rd_seq(8'h00, 9, ra);
    chk("R2 read address acks", ra, 3'b111);
    chk("R5 count byte offset 0", rbuf[0], 8'h08);
    for (int i = 0; i < 9; i++) chk("R7 reset map byte / R6 wrap", rbuf[i+1], exp_map[i]);

    // R3 R5 R7: table of single-byte writes with read-back
    for (int k = 0; k < 8; k++) begin
      wr_seq(8'hD4, {5'd0, VEC[k][18:16]}, 8'd1, {24'd0, VEC[k][15:8]}, 1, 1'b1, wa);
      chk("R3 write acks", wa[3:0], 4'hF);
      rd_seq({5'd0, VEC[k][18:16]}, 1, ra);
      chk("R5 count byte", rbuf[0], 8'd8 - {5'd0, VEC[k][18:16]});
      chk("R7 read-back", rbuf[1], VEC[k][7:0]);
    end
    chk("R7 out3 enable from bit 5", oe3, 0);
    chk("R7 out4 enable from bit 4", oe4, 1);
    chk("R3 divider 1 port", div1, 8'hA5);
    chk("R3 divider 2 port", div2, 8'h3C);

    // R6: write wraps from offset 7 to 0 and 1
    wr_seq(8'hD4, 8'h07, 8'd3, {8'h00, 8'h55, 8'h20, 8'hEE}, 3, 1'b1, wa);
    chk("R3 three-byte acks", wa[5:0], 6'h3F);
    chk("R6 wrap out3", oe3, 1);
    chk("R6 wrap out4", oe4, 0);
    chk("R6 wrap divider 1", div1, 8'h55);

    // R4: byte beyond the count
    wr_seq(8'hD4, 8'h02, 8'd1, {16'd0, 8'h99, 8'h11}, 2, 1'b1, wa);
    chk("R4 byte in count acked", wa[3], 1);
    chk("R4 extra byte nacked", wa[4], 0);
    chk("R4 extra byte not stored", div2, 8'h11);

    // R4: count of zero
    wr_seq(8'hD4, 8'h01, 8'd0, {24'd0, 8'h42}, 1, 1'b1, wa);
    chk("R4 zero count nack", wa[3], 0);
    chk("R4 zero count no store", div1, 8'h55);

    // R2: foreign address
    wr_seq(8'hA0, 8'h01, 8'd1, {24'd0, 8'h66}, 1, 1'b1, wa);
    chk("R2 foreign address no ack", wa[3:0], 4'h0);
    chk("R2 foreign address ignored", div1, 8'h55);

    // R9: STOP in the middle keeps the finished byte
    wr_seq(8'hD4, 8'h02, 8'd3, {24'd0, 8'h77}, 1, 1'b1, wa);
    chk("R9 stop mid-write acks", wa[3:0], 4'hF);
    chk("R9 finished byte kept", div2, 8'h77);

    // R9: START mid-write goes back to address decode, pointer kept
    wr_seq(8'hD4, 8'h02, 8'd2, {24'd0, 8'h44}, 1, 1'b0, wa);
    bus_start();
    send_byte(8'hD5, r);
    chk("R9 restart read address ack", r, 1);
    recv_byte(1'b0, rbuf[0]);
    recv_byte(1'b1, rbuf[1]);
    bus_stop();
    chk("R9 count after restart", rbuf[0], 8'h05);
    chk("R9 data after restart", rbuf[1], 8'h00);
    chk("R9 byte before restart kept", div2, 8'h44);

    // R8: after the host NACK, SDA stays released
    rd_seq(8'h06, 1, ra);
    chk("R7 id byte", rbuf[1], 8'h01);
    clk_bit(1'b1, r);
    chk("R8 released after nack", r, 1);
    chk("R8 no drive after nack", sda_oe, 0);
    bus_stop();

    // R6: offset taken modulo 8
    rd_seq(8'h09, 1, ra);
    chk("R6 offset modulo count", rbuf[0], 8'h07);
    chk("R6 offset modulo data", rbuf[1], 8'h55);

    chk("R10 sda steady while scl high", viol, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule